// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt request sources for a processor core and, each cycle, picks the most urgent one that software allows. It presents that choice to the core as a valid flag and a fixed 14-bit vector address. The core answers with an acknowledge when it takes the interrupt and with a return pulse when the handler ends.

The sources are:
- a reset/power-up request and a power-down request, neither of which can be masked;
- three configurable external lines, each sensing either edges or levels;
- two external lines that are always level-sensitive;
- one edge-sensitive external line that software can force and clear;
- two serial-port requests, plus a second pair shared with two of the external lines;
- a DMA-done request and a timer request.

Software programs a per-source mask, a control word, a force/clear strobe and global enable/disable strobes. The control word holds the sensing mode of each configurable line, the nesting policy and the selection for the shared pair.

External pins are active-low and asynchronous. They pass through a synchronizer before any edge or level decision. The serial-port, DMA and timer requests are single-cycle internal pulses that are held in a latch until they are serviced.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Priority, from highest to lowest, with its vector:
  - slot 0, reset request: 0x0000
  - slot 1, power-down (falling edge of `pwd_n`): 0x002C
  - slot 2, `irq2_n`: 0x0004
  - slot 3, `irql1_n`: 0x0008
  - slot 4, `irql0_n`: 0x000C
  - slot 5, `sp0_tx`: 0x0010
  - slot 6, `sp0_rx`: 0x0014
  - slot 7, `irqe_n`: 0x0018
  - slot 8, `dma_done`: 0x001C
  - slot 9, `sp1_tx` or `irq1_n`: 0x0020
  - slot 10, `sp1_rx` or `irq0_n`: 0x0024
  - slot 11, `timer_tick`: 0x0028
  
  With several sources pending, `irq_vector` shows the highest-priority one.
- R2: Each slot's request is ANDed with bit k of the mask, where the mask bit index equals the slot number. The mask is written by `mask_wr` with `mask_data`. Slots 0 and 1 ignore the mask.
- R3: `irql1_n` and `irql0_n` are level-sensitive. Their request follows the synchronized pin and is never latched.
- R4: In the cycle after a clock edge at which `mask_wr` is high, `irq_valid` is low. In the following cycle, servicing resumes.
- R5: `ctrl_data` bits 0, 1 and 2 make `irq0_n`, `irq1_n` and `irq2_n` edge-sensitive when set (1 = edge, 0 = level). An edge-mode line latches its falling edge, so the request stays pending after the pin returns high.
- R6: `ctrl_data` bit 3 controls nesting.
  - When it is 0, no grant is made while any interrupt is in service, until `rti`.
  - When it is 1, only a slot of strictly higher priority than the innermost in-service slot is granted.
  - `rti` retires the innermost in-service slot.
- R7: A `force_clr_wr` with `force_clr_data` bit 0 set sets the slot 7 latch. With bit 1 set, it clears that latch. Force wins when both bits are set.
- R8: `dis_ints` blocks all grants, including power-down, whatever the mask says. `ena_ints` restores them, and `dis_ints` wins if both are high. Servicing is enabled out of reset.
- R9: An acknowledge (`irq_valid` and `irq_ack` high at a clock edge) clears the edge latch of the granted slot.
- R10: The reset request (slot 0) is granted even while servicing is globally disabled.
- R11: `ctrl_data` bit 4 selects what drives slots 9 and 10.
  - 0: `sp1_tx` and `sp1_rx`.
  - 1: `irq1_n` and `irq0_n`; the serial-port pulses are then ignored.
- R12: After reset, the mask and the control word are zero and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_req | input | 1 | Reset/power-up request pulse |
| pwd_n | input | 1 | Power-down pin, falling edge requests |
| irq2_n | input | 1 | Configurable external line 2 |
| irql1_n | input | 1 | Level external line 1 |
| irql0_n | input | 1 | Level external line 0 |
| irqe_n | input | 1 | Forceable edge external line |
| irq1_n | input | 1 | Configurable external line 1 |
| irq0_n | input | 1 | Configurable external line 0 |
| sp0_tx | input | 1 | Serial port 0 transmit request pulse |
| sp0_rx | input | 1 | Serial port 0 receive request pulse |
| dma_done | input | 1 | DMA completion pulse |
| sp1_tx | input | 1 | Serial port 1 transmit request pulse |
| sp1_rx | input | 1 | Serial port 1 receive request pulse |
| timer_tick | input | 1 | Timer request pulse |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 12 | New mask value |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_data | input | 5 | New control word |
| force_clr_wr | input | 1 | Force/clear strobe for slot 7 |
| force_clr_data | input | 2 | Bit 0 force, bit 1 clear |
| ena_ints | input | 1 | Global enable strobe |
| dis_ints | input | 1 | Global disable strobe |
| rti | input | 1 | Return-from-interrupt pulse |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_vector | output | 14 | Vector of the offered interrupt |
| irq_ack | input | 1 | Core takes the offered interrupt |

## Verification
A wrong internal state shows up at `irq_valid` and `irq_vector` within the cycle after the faulty register update, because both outputs are decoded without a register from the latches, mask, in-service set and control state.

Each kind of fault has its own signature:
- A stale edge latch keeps a vector alive after its acknowledge and return.
- A lost blanking flag lets a grant through in the cycle right after a mask write.
- A wrong in-service record either admits a lower-priority vector during a handler or keeps the valid flag low after `rti`.
- Wrong synchronizer depth only shifts the cycle in which a pin's vector appears, so checks are placed after the synchronizer has settled.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NUM_SRC = 12;
    localparam int VEC_W   = 14;
    localparam int NUM_PIN = 7;
    localparam int CTRL_W  = 5;
    localparam int IDX_W   = $clog2(NUM_SRC);

    // slot numbers, highest priority first
    localparam int S_RST  = 0;
    localparam int S_PWD  = 1;
    localparam int S_IRQ2 = 2;
    localparam int S_LV1  = 3;
    localparam int S_LV0  = 4;
    localparam int S_S0TX = 5;
    localparam int S_S0RX = 6;
    localparam int S_IRQE = 7;
    localparam int S_DMA  = 8;
    localparam int S_SL9  = 9;
    localparam int S_SL10 = 10;
    localparam int S_TMR  = 11;

    // synchronized pin positions
    localparam int P_PWD  = 0;
    localparam int P_IRQ2 = 1;
    localparam int P_LV1  = 2;
    localparam int P_LV0  = 3;
    localparam int P_IRQE = 4;
    localparam int P_IRQ1 = 5;
    localparam int P_IRQ0 = 6;

    // control word fields
    localparam int C_EDGE0 = 0;
    localparam int C_EDGE1 = 1;
    localparam int C_EDGE2 = 2;
    localparam int C_NEST  = 3;
    localparam int C_PINS  = 4;

    localparam logic [NUM_SRC-1:0] NONMASK = NUM_SRC'((1 << S_RST) | (1 << S_PWD));

    typedef struct packed {
        logic [NUM_SRC-1:0] lat;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] isr;
        logic [CTRL_W-1:0]  ctrl;
        logic               en;
        logic               blank;
    } vic_state_t;

    // power-down sits second in priority but uses the top vector
    function automatic logic [VEC_W-1:0] slot_vector(input logic [IDX_W-1:0] k);
        logic [VEC_W-1:0] v;
        if (k == IDX_W'(S_RST))
            v = '0;
        else if (k == IDX_W'(S_PWD))
            v = VEC_W'(4 * (NUM_SRC - 1));
        else
            v = VEC_W'(4 * (int'(k) - 1));
        return v;
    endfunction

endpackage

// File: rtl/vic_pin_sync.sv
module vic_pin_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] asserted,
    output logic [WIDTH-1:0] fall
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;
        logic              prev_d, prev_q;

        always_comb begin
            sh_d   = {sh_q[STAGES-2:0], pin_n[g]};
            prev_d = sh_q[STAGES-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q   <= '1;
                prev_q <= 1'b1;
            end else begin
                sh_q   <= sh_d;
                prev_q <= prev_d;
            end
        end

        assign asserted[g] = ~sh_q[STAGES-1];
        assign fall[g]     = prev_q & ~sh_q[STAGES-1];
    end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int WIDTH = 12,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req,
    output logic             found,
    output logic [IW-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_req,
    input  logic                pwd_n,
    input  logic                irq2_n,
    input  logic                irql1_n,
    input  logic                irql0_n,
    input  logic                irqe_n,
    input  logic                irq1_n,
    input  logic                irq0_n,
    input  logic                sp0_tx,
    input  logic                sp0_rx,
    input  logic                dma_done,
    input  logic                sp1_tx,
    input  logic                sp1_rx,
    input  logic                timer_tick,
    input  logic                mask_wr,
    input  logic [NUM_SRC-1:0]  mask_data,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_data,
    input  logic                force_clr_wr,
    input  logic [1:0]          force_clr_data,
    input  logic                ena_ints,
    input  logic                dis_ints,
    input  logic                rti,
    output logic                irq_valid,
    output logic [VEC_W-1:0]    irq_vector,
    input  logic                irq_ack
);

    vic_state_t st_d, st_q;

    logic [NUM_PIN-1:0] pin_vec, pin_lvl, pin_fall;
    logic [NUM_SRC-1:0] set_ev, lvl_src, lvl_sel, req, armed, gated;
    logic               win_found, isr_found, allow, take, pins_mode;
    logic [IDX_W-1:0]   win_idx, isr_idx;

    assign pin_vec = {irq0_n, irq1_n, irqe_n, irql0_n, irql1_n, irq2_n, pwd_n};

    vic_pin_sync #(
        .WIDTH  (NUM_PIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (pin_vec),
        .asserted (pin_lvl),
        .fall     (pin_fall)
    );

    assign pins_mode = st_q.ctrl[C_PINS];

    // per-slot edge event and level source; lvl_sel picks which one counts
    always_comb begin
        set_ev          = '0;
        lvl_src         = '0;
        lvl_sel         = '0;

        set_ev[S_RST]   = rst_req;
        lvl_src[S_RST]  = rst_req;
        set_ev[S_PWD]   = pin_fall[P_PWD];
        lvl_src[S_PWD]  = pin_lvl[P_PWD];
        set_ev[S_IRQ2]  = pin_fall[P_IRQ2];
        lvl_src[S_IRQ2] = pin_lvl[P_IRQ2];
        lvl_sel[S_IRQ2] = ~st_q.ctrl[C_EDGE2];
        set_ev[S_LV1]   = pin_fall[P_LV1];
        lvl_src[S_LV1]  = pin_lvl[P_LV1];
        lvl_sel[S_LV1]  = 1'b1;
        set_ev[S_LV0]   = pin_fall[P_LV0];
        lvl_src[S_LV0]  = pin_lvl[P_LV0];
        lvl_sel[S_LV0]  = 1'b1;
        set_ev[S_S0TX]  = sp0_tx;
        lvl_src[S_S0TX] = sp0_tx;
        set_ev[S_S0RX]  = sp0_rx;
        lvl_src[S_S0RX] = sp0_rx;
        set_ev[S_IRQE]  = pin_fall[P_IRQE];
        lvl_src[S_IRQE] = pin_lvl[P_IRQE];
        set_ev[S_DMA]   = dma_done;
        lvl_src[S_DMA]  = dma_done;
        set_ev[S_TMR]   = timer_tick;
        lvl_src[S_TMR]  = timer_tick;

        if (pins_mode) begin
            set_ev[S_SL9]   = pin_fall[P_IRQ1];
            lvl_src[S_SL9]  = pin_lvl[P_IRQ1];
            lvl_sel[S_SL9]  = ~st_q.ctrl[C_EDGE1];
            set_ev[S_SL10]  = pin_fall[P_IRQ0];
            lvl_src[S_SL10] = pin_lvl[P_IRQ0];
            lvl_sel[S_SL10] = ~st_q.ctrl[C_EDGE0];
        end else begin
            set_ev[S_SL9]   = sp1_tx;
            lvl_src[S_SL9]  = sp1_tx;
            set_ev[S_SL10]  = sp1_rx;
            lvl_src[S_SL10] = sp1_rx;
        end
    end

    assign req   = (lvl_sel & lvl_src) | (~lvl_sel & st_q.lat);
    assign armed = req & (st_q.mask | NONMASK);
    assign gated = st_q.en ? armed : (armed & NUM_SRC'(1 << S_RST));

    vic_prio_pick #(.WIDTH(NUM_SRC)) u_pick_req (
        .req   (gated),
        .found (win_found),
        .idx   (win_idx)
    );

    vic_prio_pick #(.WIDTH(NUM_SRC)) u_pick_isr (
        .req   (st_q.isr),
        .found (isr_found),
        .idx   (isr_idx)
    );

    always_comb begin
        if (st_q.blank)
            allow = 1'b0;
        else if (!st_q.ctrl[C_NEST])
            allow = ~isr_found;
        else
            allow = ~isr_found | (win_idx < isr_idx);
    end

    assign irq_valid  = win_found & allow;
    assign irq_vector = slot_vector(win_idx);
    assign take       = irq_valid & irq_ack;

    always_comb begin
        st_d = st_q;

        // latches: a new event beats the clear from a same-cycle acknowledge
        if (take)
            st_d.lat[win_idx] = 1'b0;
        st_d.lat = st_d.lat | set_ev;
        if (force_clr_wr) begin
            if (force_clr_data[1])
                st_d.lat[S_IRQE] = 1'b0;
            if (force_clr_data[0])
                st_d.lat[S_IRQE] = 1'b1;
        end

        // in-service set: retire innermost first, then record the new grant
        if (rti && isr_found)
            st_d.isr[isr_idx] = 1'b0;
        if (take)
            st_d.isr[win_idx] = 1'b1;

        if (mask_wr)
            st_d.mask = mask_data;
        st_d.blank = mask_wr;

        if (ctrl_wr)
            st_d.ctrl = ctrl_data;

        if (dis_ints)
            st_d.en = 1'b0;
        else if (ena_ints)
            st_d.en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lat   <= '0;
            st_q.mask  <= '0;
            st_q.isr   <= '0;
            st_q.ctrl  <= '0;
            st_q.en    <= 1'b1;
            st_q.blank <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               mask_wr,
    input logic               dis_ints,
    input logic               irq_valid,
    input logic [VEC_W-1:0]   irq_vector,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] isr_q,
    input logic               nest_q
);

    // R1: offered vectors lie on the 4-byte grid of the map
    p_vec_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector[1:0] == 2'b00 && irq_vector <= VEC_W'(4 * (NUM_SRC - 1))));

    // R2: the timer is only offered while its mask bit is set
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_vector == VEC_W'(4 * (S_TMR - 1))) |-> mask_q[S_TMR]);

    // R4: nothing is offered in the cycle after a mask write
    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> !irq_valid);

    // R6: sequential mode holds off grants while a handler runs
    p_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_q && isr_q != '0) |-> !irq_valid);

    // R8: after a disable, only the reset vector can be offered
    p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dis_ints |=> (!irq_valid || irq_vector == '0));

endmodule

bind vec_irq_ctrl vic_checker u_vic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr    (mask_wr),
    .dis_ints   (dis_ints),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .mask_q     (st_q.mask),
    .isr_q      (st_q.isr),
    .nest_q     (st_q.ctrl[vic_pkg::C_NEST])
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_req, pwd_n, irq2_n, irql1_n, irql0_n, irqe_n, irq1_n, irq0_n;
    logic        sp0_tx, sp0_rx, dma_done, sp1_tx, sp1_rx, timer_tick;
    logic        mask_wr, ctrl_wr, force_clr_wr, ena_ints, dis_ints, rti, irq_ack;
    logic [11:0] mask_data;
    logic [4:0]  ctrl_data;
    logic [1:0]  force_clr_data;
    logic        irq_valid;
    logic [13:0] irq_vector;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .pwd_n(pwd_n),
        .irq2_n(irq2_n), .irql1_n(irql1_n), .irql0_n(irql0_n), .irqe_n(irqe_n),
        .irq1_n(irq1_n), .irq0_n(irq0_n), .sp0_tx(sp0_tx), .sp0_rx(sp0_rx),
        .dma_done(dma_done), .sp1_tx(sp1_tx), .sp1_rx(sp1_rx), .timer_tick(timer_tick),
        .mask_wr(mask_wr), .mask_data(mask_data), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .force_clr_wr(force_clr_wr), .force_clr_data(force_clr_data),
        .ena_ints(ena_ints), .dis_ints(dis_ints), .rti(rti),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack)
    );

    function automatic logic [13:0] exp_vec(input int k);
        if (k == 0) return 14'h0;
        if (k == 1) return 14'h2C;
        return 14'((k - 1) * 4);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {rst_req, sp0_tx, sp0_rx, dma_done, sp1_tx, sp1_rx, timer_tick} = '0;
        {pwd_n, irq2_n, irql1_n, irql0_n, irqe_n, irq1_n, irq0_n} = '1;
        {mask_wr, ctrl_wr, force_clr_wr, ena_ints, dis_ints, rti, irq_ack} = '0;
        mask_data = '0; ctrl_data = '0; force_clr_data = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic set_mask(input logic [11:0] m);
        mask_wr = 1'b1; mask_data = m;
        tick(1);
        mask_wr = 1'b0;
        tick(2);
    endtask

    task automatic set_ctrl(input logic [4:0] c);
        ctrl_wr = 1'b1; ctrl_data = c;
        tick(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1; tick(1); rti = 1'b0;
    endtask

    task automatic raise(input int k);
        case (k)
            0:  begin rst_req = 1'b1; tick(1); rst_req = 1'b0; end
            1:  pwd_n = 1'b0;
            2:  irq2_n = 1'b0;
            3:  irql1_n = 1'b0;
            4:  irql0_n = 1'b0;
            5:  begin sp0_tx = 1'b1; tick(1); sp0_tx = 1'b0; end
            6:  begin sp0_rx = 1'b1; tick(1); sp0_rx = 1'b0; end
            7:  irqe_n = 1'b0;
            8:  begin dma_done = 1'b1; tick(1); dma_done = 1'b0; end
            9:  begin sp1_tx = 1'b1; tick(1); sp1_tx = 1'b0; end
            10: begin sp1_rx = 1'b1; tick(1); sp1_rx = 1'b0; end
            default: begin timer_tick = 1'b1; tick(1); timer_tick = 1'b0; end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_up();
    end

    initial begin
        // R12: reset state, mask cleared so a pending timer is not offered
        do_reset();
        check("R12 valid after reset", irq_valid, 0);
        raise(11); tick(3);
        check("R12 mask zero after reset", irq_valid, 0);

        // R1: every source alone
        for (int k = 0; k < 12; k++) begin
            do_reset(); set_mask('1);
            raise(k); tick(5);
            check("R1 single valid", irq_valid, 1);
            check("R1 single vector", irq_vector, exp_vec(k));
        end

        // R1: every pair, the higher priority wins
        for (int i = 0; i < 12; i++) begin
            for (int j = i + 1; j < 12; j++) begin
                do_reset(); set_mask('1);
                raise(j); raise(i); tick(5);
                check("R1 pair vector", {irq_valid, 17'd0, irq_vector}, {1'b1, 17'd0, exp_vec(i)});
            end
        end

        // R2: masked timer held back, released by mask; power-down ignores mask
        do_reset(); set_mask(12'h7FF);
        raise(11); tick(3);
        check("R2 masked timer", irq_valid, 0);
        set_mask('1);
        check("R2 unmasked timer", irq_vector, 14'h28);
        check("R2 unmasked timer valid", irq_valid, 1);
        do_reset();
        raise(1); tick(5);
        check("R2 power-down unmaskable", {irq_valid, irq_vector}, {1'b1, 14'h2C});

        // R3: level line follows its pin
        do_reset(); set_mask('1);
        irql0_n = 1'b0; tick(4);
        check("R3 level asserted", {irq_valid, irq_vector}, {1'b1, 14'h0C});
        irql0_n = 1'b1; tick(4);
        check("R3 level released", irq_valid, 0);

        // R4: blanking after a mask write
        do_reset(); set_mask('1);
        raise(11); tick(3);
        check("R4 pending before write", irq_valid, 1);
        mask_wr = 1'b1; mask_data = '1;
        tick(1);
        mask_wr = 1'b0;
        check("R4 blanked cycle", irq_valid, 0);
        tick(1);
        check("R4 resumed", irq_valid, 1);

        // R5: irq2 level versus edge
        do_reset(); set_mask('1);
        irq2_n = 1'b0; tick(5); irq2_n = 1'b1; tick(5);
        check("R5 level pulse gone", irq_valid, 0);
        do_reset(); set_mask('1); set_ctrl(5'b00100);
        irq2_n = 1'b0; tick(5); irq2_n = 1'b1; tick(5);
        check("R5 edge latched", {irq_valid, irq_vector}, {1'b1, 14'h04});

        // R9: acknowledge clears the latch
        do_ack(); do_rti(); tick(1);
        check("R9 irq2 latch cleared", irq_valid, 0);
        do_reset(); set_mask('1);
        raise(5); tick(2);
        do_ack(); do_rti(); tick(1);
        check("R9 sp0 tx latch cleared", irq_valid, 0);

        // R6: sequential mode
        do_reset(); set_mask('1);
        raise(11); tick(3); do_ack();
        irq2_n = 1'b0; tick(5);
        check("R6 sequential hold", irq_valid, 0);
        do_rti();
        check("R6 after rti", {irq_valid, irq_vector}, {1'b1, 14'h04});

        // R6: nesting mode
        do_reset(); set_mask('1); set_ctrl(5'b01000);
        raise(11); tick(3); do_ack();
        irq2_n = 1'b0; tick(5);
        check("R6 nested preempt", {irq_valid, irq_vector}, {1'b1, 14'h04});
        do_ack();
        raise(8); tick(3);
        check("R6 lower blocked while nested", irq_valid, 0);
        irq2_n = 1'b1; tick(5);
        do_rti();
        check("R6 dma above timer after rti", {irq_valid, irq_vector}, {1'b1, 14'h1C});

        // R7: force and clear of the forceable line
        do_reset(); set_mask('1);
        force_clr_wr = 1'b1; force_clr_data = 2'b01; tick(1);
        force_clr_wr = 1'b0;
        check("R7 forced", {irq_valid, irq_vector}, {1'b1, 14'h18});
        force_clr_wr = 1'b1; force_clr_data = 2'b10; tick(1);
        force_clr_wr = 1'b0;
        check("R7 cleared", irq_valid, 0);

        // R8: global disable also gates power-down
        do_reset();
        dis_ints = 1'b1; tick(1); dis_ints = 1'b0;
        pwd_n = 1'b0; tick(5);
        check("R8 disabled", irq_valid, 0);
        ena_ints = 1'b1; tick(1); ena_ints = 1'b0;
        check("R8 enabled", {irq_valid, irq_vector}, {1'b1, 14'h2C});

        // R10: reset request passes global disable
        do_reset();
        dis_ints = 1'b1; tick(1); dis_ints = 1'b0;
        raise(0); tick(2);
        check("R10 reset while disabled", {irq_valid, irq_vector}, {1'b1, 14'h00});

        // R11: slot 9 taken from the pin
        do_reset(); set_mask('1); set_ctrl(5'b10000);
        raise(9); tick(3);
        check("R11 serial pulse ignored", irq_valid, 0);
        irq1_n = 1'b0; tick(4);
        check("R11 pin drives slot 9", {irq_valid, irq_vector}, {1'b1, 14'h20});

        finish_up();
    end

endmodule